// File: doc/BRIEF.md
# Cache Sub-Bank Collision Arbiter

This block decides, in every cycle, which of three requesters may use the shared data-cache arrays. The three requesters are a test-register access port, the store-buffer drain and the cache line fill/victim path. Each requester presents a valid flag and a byte address. The arbiter turns each address into a physical placement key made of bank, half-bank and 4 KB sub-bank. Requesters whose keys differ all go ahead in the same cycle. When keys are equal, the requesters are serialised by a fixed priority. A requester that loses sees its stall flag, keeps its request unchanged and is evaluated again in the next cycle.

The grants are combinational from the current requests. Only one piece of state exists: a starvation counter for the fill/victim path. It lets a long-waiting fill win over the store-buffer drain. The bank bit comes from one of two address positions, chosen by a configuration input. This choice decides which addresses alias onto the same bank.

Top module: `cache_bank_arbiter`

## Requirements
- R1: Each address maps to a key made of the sub-bank field (address bits 13:12), the half-bank field (address bit HALF_BIT, default 15) and the bank field (address bit 23 when `bank_sel` is 1, address bit 14 when it is 0). Two valid requests collide only when all three fields are equal. The unselected bank bit has no effect.
- R2: Valid requests that collide with no other valid request are all granted in the same cycle.
- R3: A valid test-port request is always granted.
- R4: When the store-buffer request and the fill request collide and the fill path is not being forced, the store buffer is granted and the fill request is denied.
- R5: A fill or store-buffer request that collides with a valid test-port request is denied.
- R6: A requester whose valid flag is low never receives a grant.
- R7: A stall flag is high exactly when its requester is valid and not granted.
- R8: After the fill request has been denied in 8 consecutive cycles (STARVE_LIMIT), it is granted in the next cycle even when the colliding store-buffer request is present. The store buffer is denied in that cycle.
- R9: The forced fill grant never overrides a colliding test-port request. The force stays armed until the fill request is actually granted.
- R10: The count of consecutive denials restarts from zero when the fill request is granted or when its valid flag is low for a cycle.
- R11: After reset the denial count is zero, so a fill request that collides with the store buffer is denied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_sel | input | 1 | Bank bit source: 1 selects address bit 23, 0 selects bit 14 |
| tst_vld | input | 1 | Test-register port request valid |
| tst_addr | input | ADDR_W (32) | Test-register port address |
| sbd_vld | input | 1 | Store-buffer drain request valid |
| sbd_addr | input | ADDR_W (32) | Store-buffer drain address |
| fil_vld | input | 1 | Fill/victim request valid |
| fil_addr | input | ADDR_W (32) | Fill/victim address |
| tst_gnt | output | 1 | Test-register port granted |
| sbd_gnt | output | 1 | Store-buffer drain granted |
| fil_gnt | output | 1 | Fill/victim granted |
| tst_stall | output | 1 | Test-register port must hold its request |
| sbd_stall | output | 1 | Store buffer must hold its request |
| fil_stall | output | 1 | Fill/victim must hold its request |

## Verification
The hardest case to reach is the forced fill grant. It needs eight cycles in a row in which the fill request is valid and loses. Then the next cycle must put the forced grant against a colliding store-buffer request, or against a test-port request that still has to win. A full sweep over keys, valid patterns and both bank selections reaches this state many times in passing, because a reference model in the bench carries the denial count across every step. Directed runs then build the count on purpose and break it with a test-port collision, a dropped valid or a grant, to check that the force is held and cleared.

// File: rtl/cba_pkg.sv
package cba_pkg;

  // Physical placement of an access inside the cache arrays.
  typedef struct packed {
    logic       bank;
    logic       half;
    logic [1:0] sub;
  } cba_key_t;

  localparam int unsigned NUM_REQ = 3;
  localparam int unsigned IDX_TST = 0;
  localparam int unsigned IDX_SBD = 1;
  localparam int unsigned IDX_FIL = 2;

  // Two requests share a sub-array only when every placement field agrees.
  function automatic logic keys_match(input cba_key_t a, input cba_key_t b);
    return (a.bank == b.bank) && (a.half == b.half) && (a.sub == b.sub);
  endfunction

endpackage

// File: rtl/cba_decode.sv
module cba_decode
  import cba_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SUB_LO   = 12,
  parameter int unsigned HALF_BIT = 15,
  parameter int unsigned BANK_LO  = 14,
  parameter int unsigned BANK_HI  = 23
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_sel,
  output cba_key_t          key
);

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;

  always_comb begin
    key.sub  = addr[SUB_LO +: 2];
    key.half = addr[HALF_BIT];
    key.bank = bank_sel ? addr[BANK_HI] : addr[BANK_LO];
  end

endmodule

// File: rtl/cba_starve.sv
module cba_starve #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fil_vld,
  input  logic fil_gnt,
  output logic force_fill
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [CW-1:0] deny_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deny_cnt <= '0;
    end else if (fil_vld && !fil_gnt) begin
      if (deny_cnt != CMAX) deny_cnt <= deny_cnt + 1'b1;
    end else begin
      deny_cnt <= '0;
    end
  end

  assign force_fill = (deny_cnt == CMAX);

endmodule

// File: rtl/cba_prio.sv
module cba_prio (
  input  logic tst_vld,
  input  logic sbd_vld,
  input  logic fil_vld,
  input  logic col_ts,
  input  logic col_tf,
  input  logic col_sf,
  input  logic force_fill,
  output logic tst_gnt,
  output logic sbd_gnt,
  output logic fil_gnt
);

  logic tst_blocks_sbd, tst_blocks_fil, sbd_blocks_fil, fil_takes_sbd;

  always_comb begin
    tst_blocks_sbd = tst_vld && col_ts;
    tst_blocks_fil = tst_vld && col_tf;
    sbd_blocks_fil = sbd_vld && col_sf && !force_fill;
    fil_takes_sbd  = fil_vld && col_sf && force_fill;

    tst_gnt = tst_vld;
    sbd_gnt = sbd_vld && !tst_blocks_sbd && !fil_takes_sbd;
    fil_gnt = fil_vld && !tst_blocks_fil && !sbd_blocks_fil;
  end

endmodule

// File: rtl/cache_bank_arbiter.sv
module cache_bank_arbiter
  import cba_pkg::*;
#(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned HALF_BIT     = 15,
  parameter int unsigned STARVE_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel,
  input  logic              tst_vld,
  input  logic [ADDR_W-1:0] tst_addr,
  input  logic              sbd_vld,
  input  logic [ADDR_W-1:0] sbd_addr,
  input  logic              fil_vld,
  input  logic [ADDR_W-1:0] fil_addr,
  output logic              tst_gnt,
  output logic              sbd_gnt,
  output logic              fil_gnt,
  output logic              tst_stall,
  output logic              sbd_stall,
  output logic              fil_stall
);

  logic [NUM_REQ-1:0][ADDR_W-1:0] req_addr;
  cba_key_t [NUM_REQ-1:0]         req_key;

  assign req_addr[IDX_TST] = tst_addr;
  assign req_addr[IDX_SBD] = sbd_addr;
  assign req_addr[IDX_FIL] = fil_addr;

  for (genvar gi = 0; gi < NUM_REQ; gi++) begin : g_dec
    cba_decode #(
      .ADDR_W  (ADDR_W),
      .HALF_BIT(HALF_BIT)
    ) u_dec (
      .addr    (req_addr[gi]),
      .bank_sel(bank_sel),
      .key     (req_key[gi])
    );
  end

  // Pairwise collision events, named for the checker.
  logic col_ts, col_tf, col_sf;
  assign col_ts = keys_match(req_key[IDX_TST], req_key[IDX_SBD]);
  assign col_tf = keys_match(req_key[IDX_TST], req_key[IDX_FIL]);
  assign col_sf = keys_match(req_key[IDX_SBD], req_key[IDX_FIL]);

  logic force_fill;

  cba_starve #(.LIMIT(STARVE_LIMIT)) u_starve (
    .clk       (clk),
    .rst_n     (rst_n),
    .fil_vld   (fil_vld),
    .fil_gnt   (fil_gnt),
    .force_fill(force_fill)
  );

  cba_prio u_prio (
    .tst_vld   (tst_vld),
    .sbd_vld   (sbd_vld),
    .fil_vld   (fil_vld),
    .col_ts    (col_ts),
    .col_tf    (col_tf),
    .col_sf    (col_sf),
    .force_fill(force_fill),
    .tst_gnt   (tst_gnt),
    .sbd_gnt   (sbd_gnt),
    .fil_gnt   (fil_gnt)
  );

  assign tst_stall = tst_vld && !tst_gnt;
  assign sbd_stall = sbd_vld && !sbd_gnt;
  assign fil_stall = fil_vld && !fil_gnt;

endmodule

// File: rtl/cba_chk.sv
module cba_chk #(
  parameter int unsigned STARVE_LIMIT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic tst_vld,
  input logic sbd_vld,
  input logic fil_vld,
  input logic tst_gnt,
  input logic sbd_gnt,
  input logic fil_gnt,
  input logic tst_stall,
  input logic sbd_stall,
  input logic fil_stall,
  input logic col_ts,
  input logic col_tf,
  input logic col_sf
);

  localparam int unsigned CW = $clog2(STARVE_LIMIT + 1);
  logic [CW-1:0] ck_deny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_deny <= '0;
    else if (fil_vld && !fil_gnt) begin
      if (ck_deny != CW'(STARVE_LIMIT)) ck_deny <= ck_deny + 1'b1;
    end else ck_deny <= '0;
  end

  // R3
  tst_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_vld |-> tst_gnt);

  // R6
  idle_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(( !tst_vld && tst_gnt) || (!sbd_vld && sbd_gnt) || (!fil_vld && fil_gnt)));

  // R5
  no_dual_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((tst_gnt && sbd_gnt && col_ts) || (tst_gnt && fil_gnt && col_tf) ||
      (sbd_gnt && fil_gnt && col_sf)));

  // R2
  sbd_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sbd_vld && !(tst_vld && col_ts) && !(fil_vld && col_sf)) |-> sbd_gnt);

  // R2
  fil_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fil_vld && !(tst_vld && col_tf) && !(sbd_vld && col_sf)) |-> fil_gnt);

  // R7
  stall_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_stall || sbd_stall || fil_stall) |-> (tst_vld || sbd_vld || fil_vld));

  // R8
  starve_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_deny == CW'(STARVE_LIMIT) && fil_vld && !(tst_vld && col_tf)) |-> fil_gnt);

  // R4
  sbd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_deny != CW'(STARVE_LIMIT) && sbd_vld && fil_vld && col_sf &&
     !(tst_vld && col_ts)) |-> (sbd_gnt && !fil_gnt));

endmodule

bind cache_bank_arbiter cba_chk #(.STARVE_LIMIT(STARVE_LIMIT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tst_vld  (tst_vld),
  .sbd_vld  (sbd_vld),
  .fil_vld  (fil_vld),
  .tst_gnt  (tst_gnt),
  .sbd_gnt  (sbd_gnt),
  .fil_gnt  (fil_gnt),
  .tst_stall(tst_stall),
  .sbd_stall(sbd_stall),
  .fil_stall(fil_stall),
  .col_ts   (col_ts),
  .col_tf   (col_tf),
  .col_sf   (col_sf)
);

// File: tb/cache_bank_arbiter_tb.sv
module cache_bank_arbiter_tb;

  localparam int LIMIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_sel = 1'b0;
  logic tst_vld = 1'b0, sbd_vld = 1'b0, fil_vld = 1'b0;
  logic [31:0] tst_addr = '0, sbd_addr = '0, fil_addr = '0;
  logic tst_gnt, sbd_gnt, fil_gnt, tst_stall, sbd_stall, fil_stall;

  int n_cmp = 0;
  int n_bad = 0;
  int m_cnt = 0;
  logic e_t, e_s, e_f;
  logic [3:0] k_t, k_s, k_f;

  always #2.5 clk = ~clk;

  cache_bank_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
    .tst_vld(tst_vld), .tst_addr(tst_addr),
    .sbd_vld(sbd_vld), .sbd_addr(sbd_addr),
    .fil_vld(fil_vld), .fil_addr(fil_addr),
    .tst_gnt(tst_gnt), .sbd_gnt(sbd_gnt), .fil_gnt(fil_gnt),
    .tst_stall(tst_stall), .sbd_stall(sbd_stall), .fil_stall(fil_stall)
  );

  // Key layout used by the bench: {bank, half, sub[1:0]}.
  function automatic logic [31:0] mk_addr(input logic [3:0] key, input logic bs);
    logic [31:0] a;
    a = $urandom;
    a[13:12] = key[1:0];
    a[15]    = key[2];
    if (bs) a[23] = key[3];
    else    a[14] = key[3];
    return a;
  endfunction

  task automatic predict();
    logic forced;
    forced = (m_cnt >= LIMIT);
    e_t = tst_vld;
    e_f = fil_vld && !(tst_vld && k_t == k_f) &&
          (!(sbd_vld && k_s == k_f) || forced);
    e_s = sbd_vld && !(tst_vld && k_t == k_s) &&
          !(fil_vld && forced && k_s == k_f);
  endtask

  task automatic cmp(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gnt/stall actual=%b expected=%b (tv=%b sv=%b fv=%b kt=%h ks=%h kf=%h bs=%b cnt=%0d)",
               req, act, exp, tst_vld, sbd_vld, fil_vld, k_t, k_s, k_f, bank_sel, m_cnt);
    end
  endtask

  // Drive one request pattern, check it, then clock it into the model.
  task automatic step(input logic tv, input logic sv, input logic fv,
                      input logic [3:0] kt, input logic [3:0] ks, input logic [3:0] kf,
                      input string req);
    @(negedge clk);
    tst_vld = tv; sbd_vld = sv; fil_vld = fv;
    k_t = kt; k_s = ks; k_f = kf;
    tst_addr = mk_addr(kt, bank_sel);
    sbd_addr = mk_addr(ks, bank_sel);
    fil_addr = mk_addr(kf, bank_sel);
    #1;
    predict();
    cmp(req, {tst_gnt, sbd_gnt, fil_gnt, tst_stall, sbd_stall, fil_stall},
        {e_t, e_s, e_f, tv && !e_t, sv && !e_s, fv && !e_f});
    @(posedge clk);
    if (fv && !e_f) m_cnt = (m_cnt < LIMIT) ? m_cnt + 1 : LIMIT;
    else m_cnt = 0;
  endtask

  task automatic exp_fil(input logic exp, input string req);
    n_cmp++;
    if (fil_gnt !== exp) begin
      n_bad++;
      $display("FAIL %s: fil_gnt actual=%b expected=%b", req, fil_gnt, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tst_vld = 0; sbd_vld = 0; fil_vld = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R6 R11: reset state, nothing valid -> nothing granted or stalled
    k_t = 0; k_s = 0; k_f = 0;
    repeat (3) @(negedge clk);
    #1;
    cmp("R6 reset", {tst_gnt, sbd_gnt, fil_gnt, tst_stall, sbd_stall, fil_stall}, 6'b0);
    rst_n = 1'b1;

    // R11: fresh count, colliding sbd wins over fill
    step(0, 1, 1, 4'h0, 4'h5, 4'h5, "R11");
    exp_fil(1'b0, "R11");

    // R1 R2 R3 R4 R5 R6 R7: near-exhaustive sweep, model tracks the count
    for (int bs = 0; bs < 2; bs++) begin
      bank_sel = bs[0];
      for (int v = 0; v < 8; v++)
        for (int kt = 0; kt < 16; kt += 5)
          for (int ks = 0; ks < 16; ks++)
            for (int kf = 0; kf < 16; kf++)
              step(v[2], v[1], v[0], kt[3:0], ks[3:0], kf[3:0], "R1/R2/R3/R4/R5/R7 sweep");
    end

    // R8: 8 denials, then forced grant over the store buffer
    do_reset();
    for (int i = 0; i < LIMIT; i++) begin
      step(0, 1, 1, 4'h0, 4'h9, 4'h9, "R8 build");
      exp_fil(1'b0, "R8 denied");
    end
    step(0, 1, 1, 4'h0, 4'h9, 4'h9, "R8 forced");
    exp_fil(1'b1, "R8 forced");
    step(0, 1, 1, 4'h0, 4'h9, 4'h9, "R10 after grant");
    exp_fil(1'b0, "R10 after grant");

    // R9: force armed, test port still wins; force held until grant
    do_reset();
    for (int i = 0; i < LIMIT; i++) step(0, 1, 1, 4'h0, 4'h3, 4'h3, "R9 build");
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 1, 4'h3, 4'h3, 4'h3, "R9 tst wins");
      exp_fil(1'b0, "R9 tst wins");
    end
    step(0, 1, 1, 4'h0, 4'h3, 4'h3, "R9 held");
    exp_fil(1'b1, "R9 held");

    // R10: dropping valid restarts the count
    do_reset();
    for (int i = 0; i < 5; i++) step(0, 1, 1, 4'h0, 4'hC, 4'hC, "R10 build");
    step(0, 1, 0, 4'h0, 4'hC, 4'hC, "R10 drop");
    for (int i = 0; i < LIMIT; i++) begin
      step(0, 1, 1, 4'h0, 4'hC, 4'hC, "R10 rebuild");
      exp_fil(1'b0, "R10 rebuild");
    end
    step(0, 1, 1, 4'h0, 4'hC, 4'hC, "R10 forced");
    exp_fil(1'b1, "R10 forced");

    // R1: unselected bank bit differs while selected fields match -> collide
    do_reset();
    bank_sel = 1'b1;
    @(negedge clk);
    sbd_vld = 1; fil_vld = 1; tst_vld = 0;
    sbd_addr = 32'h0000_4000; fil_addr = 32'h0000_0000;
    #1;
    exp_fil(1'b0, "R1 bit14 ignored with bank_sel=1");
    bank_sel = 1'b0;
    #1;
    exp_fil(1'b1, "R1 bit14 used with bank_sel=0");
    @(posedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule